// File: doc/BRIEF.md
# Modulo Up-Counter Timer with Overflow Interrupt

A small timer peripheral that sits on a simple register read/write port. A 16-bit counter runs up from a programmable start value to a programmable limit. When it reaches the limit, the next count reloads the start value and raises an overflow flag. That flag can drive a level interrupt. A clock-select field gates the count, and a power-of-two prescaler divides it.

The limit and start-value registers are double-buffered. Software writes into a holding copy. The copy the counter uses is refreshed only while the clock-select field is zero, so a running period never sees a half-written setting. Writing any data to the counter register loads it with the start value currently in force. The overflow flag is cleared by a two-step sequence. Software first reads the control register while the flag is set, then writes a zero into the flag bit.

Top module: `mod_timer`

## Requirements
- R1: After reset, all four registers read 0 and `irq_o` is low.
- R2: The register byte offsets are control 0x00, counter 0x04, limit 0x08 and start value 0x4C. In the control register, bits [2:0] hold the prescale exponent, bits [4:3] the clock select, bit 6 the interrupt enable and bit 7 the overflow flag. Bit 5, bits [31:8] of control, bits [31:16] of the 16-bit registers and any unmapped offset all read 0.
- R3: With clock select 1 and prescale exponent p, the counter advances once every 2^p clocks. The first advance comes 2^p edges after the edge that wrote the control register.
- R4: With clock select 0, the counter holds its value.
- R5: The counter advances until it equals the active limit. The next advance loads the active start value and sets the overflow flag, so one period is limit − start + 1 counts.
- R6: A write of any data to the counter register loads the active start value on that edge.
- R7: Writes to the limit and start-value registers land in holding copies, and reads return those copies. The active copies take them only on an edge where the clock select is 0.
- R8: Writing 1 to the flag bit has no effect. Writing 0 to it clears the flag only if the control register was read while the flag was set, with no control write since that read.
- R9: If an overflow and a valid flag clear happen on the same edge, the flag stays set.
- R10: `irq_o` is high exactly while the flag and the interrupt enable are both 1.
- R11: The prescale divider returns to zero while the clock select is 0, so a restart always waits a full 2^p clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe (arms the flag clear) |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 7 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Overflow interrupt level |

## Verification
The bench builds the timer with its default 16-bit counter and 7-bit offset. It programs a start value of 5 and a limit of 9, so a complete wrap takes only five counts and wrap timing can be followed edge by edge. It exercises prescale exponents 0 and 2. Exponent 2 is enough to show the spacing between advances, and to tell a divider that was reset on a stop from one that kept its phase. A limit rewrite during a run, followed by a stop, shows whether the holding copy reaches the counter only at the stop.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int unsigned OFF_CTRL = 'h00;
  localparam int unsigned OFF_CNT  = 'h04;
  localparam int unsigned OFF_MOD  = 'h08;
  localparam int unsigned OFF_INIT = 'h4C;

  localparam int unsigned PS_W     = 3;
  localparam int unsigned CS_LSB   = 3;
  localparam int unsigned IE_BIT   = 6;
  localparam int unsigned FLAG_BIT = 7;

  localparam logic [1:0] CLK_OFF = 2'd0;
  localparam logic [1:0] CLK_SYS = 2'd1;
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler
  import mt_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      clk_sel_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            tick_o
);
  localparam int unsigned DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q, mask;
  logic             run;

  always_comb begin
    mask   = DIV_W'((32'd1 << ps_i) - 32'd1);
    run    = (clk_sel_i == CLK_SYS);
    tick_o = run && ((div_q & mask) == mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (!run)   div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + DIV_W'(1);
  end

  a_r11_div_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_i == CLK_OFF) |=> (div_q == '0));
endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_mod;

  always_comb begin
    at_mod = (cnt_q == mod_i);
    ovf_o  = tick_i && !load_i && at_mod;
    cnt_o  = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= init_i;
    else if (tick_i) cnt_q <= at_mod ? init_i : cnt_q + CNT_W'(1);
  end

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));
  a_r6_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(init_i)));
  a_r5_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_q == $past(init_i)));
endmodule

// File: rtl/mt_regs.sv
module mt_regs
  import mt_pkg::*;
#(
  parameter int unsigned AW    = 7,
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ovf_i,
  output logic [PS_W-1:0]  ps_o,
  output logic [1:0]       clk_sel_o,
  output logic [CNT_W-1:0] init_o,
  output logic [CNT_W-1:0] mod_o,
  output logic             load_o,
  output logic             irq_o,
  output logic [DW-1:0]    rdata_o
);
  logic [PS_W-1:0]  ps_q;
  logic [1:0]       clk_sel_q;
  logic             ie_q, flag_q, armed_q;
  logic [CNT_W-1:0] mod_buf_q, init_buf_q, mod_act_q, init_act_q;
  logic             hit_ctrl, hit_cnt, hit_mod, hit_init;
  logic             wr_ctrl, clr_req;
  logic             unused_wdata;

  always_comb begin
    hit_ctrl = (addr_i == AW'(OFF_CTRL));
    hit_cnt  = (addr_i == AW'(OFF_CNT));
    hit_mod  = (addr_i == AW'(OFF_MOD));
    hit_init = (addr_i == AW'(OFF_INIT));
    wr_ctrl  = wr_i && hit_ctrl;
    clr_req  = wr_ctrl && !wdata_i[FLAG_BIT] && armed_q;
    load_o   = wr_i && hit_cnt;
  end

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q      <= '0;
      clk_sel_q <= CLK_OFF;
      ie_q      <= 1'b0;
    end else if (wr_ctrl) begin
      ps_q      <= wdata_i[PS_W-1:0];
      clk_sel_q <= wdata_i[CS_LSB +: 2];
      ie_q      <= wdata_i[IE_BIT];
    end
  end

  // holding copies, moved to the active copies only while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_buf_q  <= '0;
      init_buf_q <= '0;
      mod_act_q  <= '0;
      init_act_q <= '0;
    end else begin
      if (wr_i && hit_mod)  mod_buf_q  <= wdata_i[CNT_W-1:0];
      if (wr_i && hit_init) init_buf_q <= wdata_i[CNT_W-1:0];
      if (clk_sel_q == CLK_OFF) begin
        mod_act_q  <= mod_buf_q;
        init_act_q <= init_buf_q;
      end
    end
  end

  // overflow has priority over a clear on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (ovf_i)        flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
      if (wr_ctrl)                        armed_q <= 1'b0;
      else if (rd_i && hit_ctrl && flag_q) armed_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl) begin
      rdata_o[PS_W-1:0]     = ps_q;
      rdata_o[CS_LSB +: 2]  = clk_sel_q;
      rdata_o[IE_BIT]       = ie_q;
      rdata_o[FLAG_BIT]     = flag_q;
    end else if (hit_cnt)  rdata_o[CNT_W-1:0] = cnt_i;
    else if (hit_mod)      rdata_o[CNT_W-1:0] = mod_buf_q;
    else if (hit_init)     rdata_o[CNT_W-1:0] = init_buf_q;
  end

  assign ps_o      = ps_q;
  assign clk_sel_o = clk_sel_q;
  assign init_o    = init_act_q;
  assign mod_o     = mod_act_q;
  assign irq_o     = flag_q & ie_q;

  a_r9_collide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> flag_q);
  a_r8_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !armed_q) |=> flag_q);
  a_r7_buf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_q != CLK_OFF) |=> ($stable(mod_act_q) && $stable(init_act_q)));
endmodule

// File: rtl/mod_timer.sv
module mod_timer
  import mt_pkg::*;
#(
  parameter int unsigned AW    = 7,
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic [PS_W-1:0]  ps;
  logic [1:0]       clk_sel;
  logic [CNT_W-1:0] init_act, mod_act, cnt;
  logic             tick, load, ovf;

  mt_regs #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .rd_i, .wr_i, .addr_i, .wdata_i,
    .cnt_i(cnt), .ovf_i(ovf), .ps_o(ps), .clk_sel_o(clk_sel),
    .init_o(init_act), .mod_o(mod_act), .load_o(load),
    .irq_o, .rdata_o
  );

  mt_prescaler u_pre (
    .clk_i, .rst_ni, .clk_sel_i(clk_sel), .ps_i(ps), .tick_o(tick)
  );

  mt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(load),
    .init_i(init_act), .mod_i(mod_act), .cnt_o(cnt), .ovf_o(ovf)
  );
endmodule

// File: tb/mod_timer_tb.sv
module mod_timer_tb;
  localparam logic [6:0] A_CTRL = 7'h00;
  localparam logic [6:0] A_CNT  = 7'h04;
  localparam logic [6:0] A_MOD  = 7'h08;
  localparam logic [6:0] A_INIT = 7'h4C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          total = 0, bad = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  mod_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr_reg(input logic [6:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [6:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_reg(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd_reg(A_CNT, v);  chk("R1 cnt", v, 32'h0);
    rd_reg(A_MOD, v);  chk("R1 mod", v, 32'h0);
    rd_reg(A_INIT, v); chk("R1 init", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_load;
    wr_reg(A_INIT, 32'd5);
    wr_reg(A_MOD, 32'd9);
    wr_reg(A_CNT, 32'h1234);
    rd_reg(A_CNT, v); chk("R6 load start", v, 32'd5);
  endtask

  task automatic t_wrap;
    wr_reg(A_CTRL, 32'h48);
    rd_reg(A_CNT, v); chk("R3 first edge", v, 32'd5);
    idle(3);
    rd_reg(A_CNT, v); chk("R5 reach limit", v, 32'd9);
    chk("R10 irq set", {31'b0, irq}, 32'h1);
    rd_reg(A_CNT, v); chk("R5 reload", v, 32'd5);
    rd_reg(A_CTRL, v); chk("R2 ctrl flag", v, 32'hC8);
  endtask

  task automatic t_stop_clear;
    wr_reg(A_CTRL, 32'hC0);
    chk("R8 write one", {31'b0, irq}, 32'h1);
    rd_reg(A_CNT, v); chk("R4 stopped", v, 32'd8);
    idle(3);
    rd_reg(A_CNT, v); chk("R4 still", v, 32'd8);
    wr_reg(A_CTRL, 32'h40);
    rd_reg(A_CTRL, v); chk("R8 unarmed", v, 32'hC0);
    wr_reg(A_CTRL, 32'h40);
    rd_reg(A_CTRL, v); chk("R8 armed clear", v, 32'h40);
    chk("R10 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_collide;
    wr_reg(A_CTRL, 32'h48);
    idle(2);
    rd_reg(A_CTRL, v); chk("R5 flag", v, 32'hC8);
    idle(3);
    wr_reg(A_CTRL, 32'h48);
    rd_reg(A_CTRL, v); chk("R9 collide", v, 32'hC8);
    wr_reg(A_CTRL, 32'h48);
    rd_reg(A_CTRL, v); chk("R8 run clear", v, 32'h48);
  endtask

  task automatic t_buffer;
    wr_reg(A_MOD, 32'd20);
    idle(1);
    rd_reg(A_CNT, v); chk("R7 old limit", v, 32'd5);
    rd_reg(A_MOD, v); chk("R7 read copy", v, 32'd20);
    wr_reg(A_CTRL, 32'h40);
    idle(1);
    wr_reg(A_CTRL, 32'h48);
    idle(3);
    rd_reg(A_CNT, v); chk("R7 new limit", v, 32'd11);
  endtask

  task automatic t_prescale;
    wr_reg(A_CTRL, 32'h40);
    wr_reg(A_CNT, 32'hFFFF);
    wr_reg(A_CTRL, 32'h0A);
    idle(3);
    rd_reg(A_CNT, v); chk("R3 ps2 hold", v, 32'd5);
    idle(3);
    rd_reg(A_CNT, v); chk("R3 ps2 step", v, 32'd6);
    chk("R10 ie off", {31'b0, irq}, 32'h0);
    rd_reg(A_CTRL, v); chk("R2 fields", v, 32'h8A);
  endtask

  task automatic t_div_reset;
    wr_reg(A_CTRL, 32'h82);
    wr_reg(A_CTRL, 32'h0A);
    idle(2);
    rd_reg(A_CNT, v); chk("R11 full wait", v, 32'd7);
    idle(1);
    rd_reg(A_CNT, v); chk("R11 tick", v, 32'd8);
  endtask

  task automatic t_fields;
    wr_reg(A_CTRL, 32'hFFFF_FF20);
    rd_reg(A_CTRL, v); chk("R2 reserved", v, 32'h0000_00FF & 32'h80 | 32'h0);
    wr_reg(A_MOD, 32'hFFFF_1234);
    rd_reg(A_MOD, v); chk("R2 upper bits", v, 32'h0000_1234);
    rd_reg(7'h10, v); chk("R2 unmapped", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_wrap();
    t_stop_clear();
    t_collide();
    t_buffer();
    t_prescale();
    t_div_reset();
    t_fields();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout exp finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule